// File: doc/BRIEF.md
# Dual Threshold Alarm Engine

This block watches up to four sampled measurement streams (supply voltage, angular rate, auxiliary converter input and temperature) and raises alarms when a chosen stream crosses a programmed limit. It has two alarm channels that run independently. Each channel picks one stream and either compares every new sample against its limit directly, or collects a window of sample-to-sample differences and compares their mean against the limit. The comparison direction (above or below) is chosen per channel. The limit is read in the same number format as the chosen stream.

A channel that fires sets a sticky status flag. The flag holds until a status-read strobe clears it. The two flags can also drive an alarm level onto one of two shared I/O lines. The polarity is programmable. That line is shared with a data-ready signal and with general-purpose outputs under a fixed priority. A single control bit chooses whether the filtered or the unfiltered copy of each stream feeds both channels.

Top module: `twin_alarm`

## Requirements
- R1: The 3-bit source code of a channel selects the stream by index: 001 = supply (index 0), 010 = rate (index 1), 101 = auxiliary input (index 2), 110 = temperature (index 3). A code of 000, 011, 100 or 111 disables the channel, and it never fires. A channel ignores strobes from every stream other than its own.
- R2: In level mode (rate enable 0), each strobe of the selected stream fires the channel if the sample is strictly greater than the limit (threshold word bit 15 = 1) or strictly less than the limit (bit 15 = 0).
- R3: Samples and limits are 14 bits wide, and the limit sits in threshold bits 13:0. For the rate and temperature streams both are two's complement. For supply and auxiliary both are unsigned.
- R4: In rate mode (rate enable 1), the first strobe after the channel is enabled only records a reference sample. Each later strobe adds the difference new minus previous to a running sum. When N differences have been summed, the channel fires if the exact mean (the sum compared with limit times N) is strictly beyond the limit in the chosen direction. The sum then restarts, and the latest sample remains the reference.
- R5: A window count N of 0 behaves as N = 1.
- R6: A firing channel sets its flag, visible from the clock edge that samples the strobe. The flag holds until a status read. Status bit 8 carries channel 0 and bit 9 carries channel 1; all other status bits read 0.
- R7: If a status read and a firing event fall in the same cycle, the flag remains set. A read with no event clears it.
- R8: With use_filt = 1 both channels compare the filtered data; with use_filt = 0 they compare the raw data.
- R9: With the alarm pin enabled, line pin_sel (0 or 1) is driven with output enable 1. It carries level 1 when any flag is set if pin_pol = 1, and the inverse of that when pin_pol = 0.
- R10: On each line the data-ready function (rdy_en, rdy_sel, rdy_lvl) wins over the alarm, and the alarm wins over the general-purpose gp_out/gp_oe values.
- R11: Changing a channel's source code or rate enable discards its reference sample and partial sum. The next strobe after the change starts a new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 4 | One-cycle sample strobe per stream, bit = stream index |
| raw_data | input | 56 | Unfiltered samples, stream s at bits 14*s+13:14*s |
| filt_data | input | 56 | Filtered samples, same layout |
| use_filt | input | 1 | 1 selects filtered data for the comparison |
| cfg_src | input | 6 | Source code per channel, channel c at bits 3*c+2:3*c |
| cfg_rate | input | 2 | Rate-of-change enable per channel |
| cfg_thr | input | 32 | Threshold word per channel at bits 16*c+15:16*c (bit 15 direction, 13:0 limit) |
| cfg_win | input | 16 | Window difference count per channel at bits 8*c+7:8*c |
| stat_rd | input | 1 | Status read strobe, clears flags |
| pin_en | input | 1 | Alarm line output enable |
| pin_pol | input | 1 | Alarm line polarity, 1 = active high |
| pin_sel | input | 1 | Alarm line select |
| rdy_en | input | 1 | Data-ready line enable |
| rdy_sel | input | 1 | Data-ready line select |
| rdy_lvl | input | 1 | Data-ready level |
| gp_out | input | 2 | General-purpose output values |
| gp_oe | input | 2 | General-purpose output enables |
| status | output | 16 | Status word, bits 9:8 are the alarm flags |
| io_out | output | 2 | Shared line output values |
| io_oe | output | 2 | Shared line output enables |

## Verification
The assertions check on every cycle that a fired channel's flag appears on the next edge. They also check that a set flag survives any cycle without a read, that a read without an event clears it, that a disabled source code never fires, and that line ownership follows the data-ready, alarm, general-purpose order. The exact compare results cannot be checked cycle by cycle: strict bounds, signed versus unsigned reading of the limit, the window mean with N = 0 and ties at limit times N, and the discarding of a partial window on reconfiguration. Only the bench's sweeps against its arithmetic model show these.

// File: rtl/twin_alarm_pkg.sv
package twin_alarm_pkg;
  localparam int NUM_SRC  = 4;
  localparam int NUM_CH   = 2;
  localparam int NUM_LINE = 2;
  localparam int STAT_LSB = 8;

  localparam logic [2:0] CODE_SUP = 3'b001;
  localparam logic [2:0] CODE_RATE = 3'b010;
  localparam logic [2:0] CODE_AUX = 3'b101;
  localparam logic [2:0] CODE_TEMP = 3'b110;

  typedef struct packed {
    logic       ok;
    logic       sgn;
    logic [1:0] idx;
  } src_map_t;

  function automatic src_map_t decode_src(input logic [2:0] code);
    src_map_t m;
    m = '{ok: 1'b0, sgn: 1'b0, idx: 2'd0};
    case (code)
      CODE_SUP:  m = '{ok: 1'b1, sgn: 1'b0, idx: 2'd0};
      CODE_RATE: m = '{ok: 1'b1, sgn: 1'b1, idx: 2'd1};
      CODE_AUX:  m = '{ok: 1'b1, sgn: 1'b0, idx: 2'd2};
      CODE_TEMP: m = '{ok: 1'b1, sgn: 1'b1, idx: 2'd3};
      default:   m = '{ok: 1'b0, sgn: 1'b0, idx: 2'd0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alm_src_mux.sv
module alm_src_mux
  import twin_alarm_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic [2:0]            sel,
  input  logic [NUM_SRC-1:0]    vld,
  input  logic [NUM_SRC*DW-1:0] raw_data,
  input  logic [NUM_SRC*DW-1:0] filt_data,
  input  logic                  use_filt,
  output logic                  active,
  output logic                  strobe,
  output logic                  sgn,
  output logic [DW-1:0]         value
);
  src_map_t map;

  always_comb begin
    map    = decode_src(sel);
    active = map.ok;
    sgn    = map.sgn;
    strobe = map.ok & vld[map.idx];
    if (use_filt) value = filt_data[map.idx*DW +: DW];
    else          value = raw_data[map.idx*DW +: DW];
  end
endmodule

// File: rtl/alm_channel.sv
module alm_channel #(
  parameter int DW = 14,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          strobe,
  input  logic          sgn,
  input  logic [DW-1:0] value,
  input  logic          rate_en,
  input  logic          thr_dir,
  input  logic [DW-1:0] thr_val,
  input  logic [CW-1:0] win,
  input  logic          restart,
  output logic          hit
);
  localparam int AW = DW + CW + 3;

  logic [DW-1:0]        prev_q, prev_d;
  logic                 ref_q, ref_d;
  logic signed [AW-1:0] sum_q, sum_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 st_en;

  logic signed [AW-1:0] val_w, prev_w, thr_w, diff, sum_add, n_w, target;
  logic [CW-1:0]        n_eff;
  logic                 last;
  logic                 lvl_hit, win_hit;

  function automatic logic signed [AW-1:0] widen(input logic [DW-1:0] x, input logic s);
    return {{(AW-DW){s & x[DW-1]}}, x};
  endfunction

  always_comb begin
    val_w   = widen(value, sgn);
    prev_w  = widen(prev_q, sgn);
    thr_w   = widen(thr_val, sgn);
    diff    = val_w - prev_w;
    sum_add = sum_q + diff;
    n_eff   = (win == '0) ? CW'(1) : win;
    n_w     = {{(AW-CW){1'b0}}, n_eff};
    target  = thr_w * n_w;
    last    = ({1'b0, cnt_q} + (CW+1)'(1)) == {1'b0, n_eff};
    lvl_hit = thr_dir ? (val_w > thr_w) : (val_w < thr_w);
    win_hit = thr_dir ? (sum_add > target) : (sum_add < target);
  end

  // next-state of the difference window
  always_comb begin
    prev_d = prev_q;
    ref_d  = ref_q;
    sum_d  = sum_q;
    cnt_d  = cnt_q;
    hit    = 1'b0;
    st_en  = restart | ~active | (strobe & rate_en);
    if (restart || !active) begin
      ref_d = 1'b0;
      sum_d = '0;
      cnt_d = '0;
    end else if (strobe && rate_en) begin
      prev_d = value;
      ref_d  = 1'b1;
      if (ref_q) begin
        if (last) begin
          hit   = win_hit;
          sum_d = '0;
          cnt_d = '0;
        end else begin
          sum_d = sum_add;
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
    if (active && strobe && !rate_en) hit = lvl_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ref_q  <= 1'b0;
      sum_q  <= '0;
      cnt_q  <= '0;
    end else if (st_en) begin
      prev_q <= prev_d;
      ref_q  <= ref_d;
      sum_q  <= sum_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/alm_line_mux.sv
module alm_line_mux #(
  parameter int NL = 2
) (
  input  logic                 rdy_en,
  input  logic [SELW-1:0]      rdy_sel,
  input  logic                 rdy_lvl,
  input  logic                 alm_en,
  input  logic [SELW-1:0]      alm_sel,
  input  logic                 alm_lvl,
  input  logic [NL-1:0]        gp_out,
  input  logic [NL-1:0]        gp_oe,
  output logic [NL-1:0]        io_out,
  output logic [NL-1:0]        io_oe
);
  localparam int SELW = (NL > 1) ? $clog2(NL) : 1;

  for (genvar l = 0; l < NL; l++) begin : g_line
    always_comb begin
      if (rdy_en && rdy_sel == SELW'(l)) begin
        io_out[l] = rdy_lvl;
        io_oe[l]  = 1'b1;
      end else if (alm_en && alm_sel == SELW'(l)) begin
        io_out[l] = alm_lvl;
        io_oe[l]  = 1'b1;
      end else begin
        io_out[l] = gp_out[l];
        io_oe[l]  = gp_oe[l];
      end
    end
  end
endmodule

// File: rtl/twin_alarm.sv
module twin_alarm
  import twin_alarm_pkg::*;
#(
  parameter int DW = 14,
  parameter int CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    smp_vld,
  input  logic [NUM_SRC*DW-1:0] raw_data,
  input  logic [NUM_SRC*DW-1:0] filt_data,
  input  logic                  use_filt,
  input  logic [NUM_CH*3-1:0]   cfg_src,
  input  logic [NUM_CH-1:0]     cfg_rate,
  input  logic [NUM_CH*16-1:0]  cfg_thr,
  input  logic [NUM_CH*CW-1:0]  cfg_win,
  input  logic                  stat_rd,
  input  logic                  pin_en,
  input  logic                  pin_pol,
  input  logic                  pin_sel,
  input  logic                  rdy_en,
  input  logic                  rdy_sel,
  input  logic                  rdy_lvl,
  input  logic [NUM_LINE-1:0]   gp_out,
  input  logic [NUM_LINE-1:0]   gp_oe,
  output logic [15:0]           status,
  output logic [NUM_LINE-1:0]   io_out,
  output logic [NUM_LINE-1:0]   io_oe
);
  localparam int TAGW = 4;

  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic              flag_en;
  logic [NUM_CH-1:0] unused_gap;
  logic              alm_lvl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          active, strobe, sgn, restart;
    logic [DW-1:0] value;
    logic [TAGW-1:0] tag_q, tag_now;

    assign tag_now       = {cfg_src[3*c +: 3], cfg_rate[c]};
    assign restart       = tag_now != tag_q;
    assign unused_gap[c] = ^cfg_thr[16*c+DW +: 15-DW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tag_q <= '0;
      else if (restart) tag_q <= tag_now;
    end

    alm_src_mux #(.DW(DW)) i_mux (
      .sel       (cfg_src[3*c +: 3]),
      .vld       (smp_vld),
      .raw_data  (raw_data),
      .filt_data (filt_data),
      .use_filt  (use_filt),
      .active    (active),
      .strobe    (strobe),
      .sgn       (sgn),
      .value     (value)
    );

    alm_channel #(.DW(DW), .CW(CW)) i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .strobe  (strobe),
      .sgn     (sgn),
      .value   (value),
      .rate_en (cfg_rate[c]),
      .thr_dir (cfg_thr[16*c+15]),
      .thr_val (cfg_thr[16*c +: DW]),
      .win     (cfg_win[CW*c +: CW]),
      .restart (restart),
      .hit     (ch_hit[c])
    );
  end

  always_comb begin
    flag_d  = ch_hit | (flag_q & ~{NUM_CH{stat_rd}});
    flag_en = (|ch_hit) | stat_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_comb begin
    status = '0;
    status[STAT_LSB +: NUM_CH] = flag_q;
    alm_lvl = pin_pol ? (|flag_q) : ~(|flag_q);
  end

  alm_line_mux #(.NL(NUM_LINE)) i_lines (
    .rdy_en  (rdy_en),
    .rdy_sel (rdy_sel),
    .rdy_lvl (rdy_lvl),
    .alm_en  (pin_en),
    .alm_sel (pin_sel),
    .alm_lvl (alm_lvl),
    .gp_out  (gp_out),
    .gp_oe   (gp_oe),
    .io_out  (io_out),
    .io_oe   (io_oe)
  );
endmodule

// File: rtl/twin_alarm_chk.sv
module twin_alarm_chk
  import twin_alarm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_SRC-1:0]  smp_vld,
  input logic [NUM_CH*3-1:0] cfg_src,
  input logic                stat_rd,
  input logic                pin_en,
  input logic                pin_pol,
  input logic                pin_sel,
  input logic                rdy_en,
  input logic                rdy_sel,
  input logic                rdy_lvl,
  input logic [15:0]         status,
  input logic [NUM_LINE-1:0] io_out,
  input logic [NUM_LINE-1:0] io_oe,
  input logic [NUM_CH-1:0]   ch_hit
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic [2:0] code;
    assign code = cfg_src[3*c +: 3];

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[c] |=> status[STAT_LSB+c]); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      status[STAT_LSB+c] && !stat_rd |=> status[STAT_LSB+c]); // R6
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd && !ch_hit[c] |=> !status[STAT_LSB+c]); // R7
    AST_READ_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd && ch_hit[c] |=> status[STAT_LSB+c]); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(code == CODE_SUP || code == CODE_RATE || code == CODE_AUX || code == CODE_TEMP)
      |-> !ch_hit[c]); // R1
    AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[c] |-> (|smp_vld)); // R2
  end

  AST_RDY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_en |-> io_oe[rdy_sel] && io_out[rdy_sel] == rdy_lvl); // R10
  AST_ALARM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_en && !(rdy_en && rdy_sel == pin_sel)
    |-> io_oe[pin_sel] && io_out[pin_sel] == (pin_pol ? (|status[9:8]) : !(|status[9:8]))); // R9
endmodule

bind twin_alarm twin_alarm_chk i_twin_alarm_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_vld (smp_vld),
  .cfg_src (cfg_src),
  .stat_rd (stat_rd),
  .pin_en  (pin_en),
  .pin_pol (pin_pol),
  .pin_sel (pin_sel),
  .rdy_en  (rdy_en),
  .rdy_sel (rdy_sel),
  .rdy_lvl (rdy_lvl),
  .status  (status),
  .io_out  (io_out),
  .io_oe   (io_oe),
  .ch_hit  (ch_hit)
);

// File: tb/test_twin_alarm.sv
module test_twin_alarm;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  smp_vld;
  logic [55:0] raw_data, filt_data;
  logic        use_filt;
  logic [5:0]  cfg_src;
  logic [1:0]  cfg_rate;
  logic [31:0] cfg_thr;
  logic [15:0] cfg_win;
  logic        stat_rd, pin_en, pin_pol, pin_sel, rdy_en, rdy_sel, rdy_lvl;
  logic [1:0]  gp_out, gp_oe;
  logic [15:0] status;
  logic [1:0]  io_out, io_oe;

  int total = 0;
  int bad = 0;
  int codes [4] = '{1, 2, 5, 6};

  always #10 clk = ~clk;

  twin_alarm i_twin_alarm (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .raw_data(raw_data),
    .filt_data(filt_data), .use_filt(use_filt), .cfg_src(cfg_src),
    .cfg_rate(cfg_rate), .cfg_thr(cfg_thr), .cfg_win(cfg_win),
    .stat_rd(stat_rd), .pin_en(pin_en), .pin_pol(pin_pol), .pin_sel(pin_sel),
    .rdy_en(rdy_en), .rdy_sel(rdy_sel), .rdy_lvl(rdy_lvl), .gp_out(gp_out),
    .gp_oe(gp_oe), .status(status), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int sval(input int s, input logic [13:0] x);
    if (s == 1 || s == 3) return int'($signed(x));
    return int'(x);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input int s, input logic [13:0] rv, input logic [13:0] fv, input bit rd);
    raw_data[s*14 +: 14]  = rv;
    filt_data[s*14 +: 14] = fv;
    smp_vld = 4'b0001 << s;
    stat_rd = rd;
    @(negedge clk);
    smp_vld = '0;
    stat_rd = 1'b0;
  endtask

  task automatic clear();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [13:0] thr_list [3] = '{14'h0005, 14'h2000, 14'h1FFF};
    rst_n = 1'b0; smp_vld = '0; raw_data = '0; filt_data = '0; use_filt = 1'b0;
    cfg_src = '0; cfg_rate = '0; cfg_thr = '0; cfg_win = '0; stat_rd = 1'b0;
    pin_en = 0; pin_pol = 0; pin_sel = 0; rdy_en = 0; rdy_sel = 0; rdy_lvl = 0;
    gp_out = '0; gp_oe = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state (R6, R10)
    check("R6 reset status", status, 0);
    check("R10 reset lines", {io_out, io_oe}, 0);

    // level mode sweep over all sources (R2, R3)
    for (int s = 0; s < 4; s++) begin
      cfg_src[2:0] = codes[s][2:0];
      cfg_rate[0]  = 1'b0;
      for (int d = 0; d < 2; d++) begin
        for (int ti = 0; ti < 3; ti++) begin
          logic [13:0] t;
          t = thr_list[ti];
          cfg_thr[15:0] = {d[0], 1'b0, t};
          for (int vi = 0; vi < 8; vi++) begin
            logic [13:0] v;
            bit e;
            case (vi)
              0: v = 14'h0000; 1: v = 14'h0001; 2: v = 14'h1FFF; 3: v = 14'h2000;
              4: v = 14'h3FFF; 5: v = t - 14'd1; 6: v = t; default: v = t + 14'd1;
            endcase
            put(s, v, v, 1'b0);
            e = d ? (sval(s, v) > sval(s, t)) : (sval(s, v) < sval(s, t));
            check("R2 R3 level compare", status[8], e);
            if (status[8]) clear();
          end
        end
      end
    end

    // disabled codes and foreign strobes (R1)
    cfg_thr[15:0] = {1'b1, 1'b0, 14'h0000};
    for (int k = 0; k < 4; k++) begin
      int cl [4] = '{0, 3, 4, 7};
      cfg_src[2:0] = cl[k][2:0];
      for (int s = 0; s < 4; s++) put(s, 14'h0100, 14'h0100, 1'b0);
      check("R1 inactive code", status, 0);
    end
    cfg_src[2:0] = 3'b001;
    put(1, 14'h0100, 14'h0100, 1'b0);
    put(2, 14'h0100, 14'h0100, 1'b0);
    put(3, 14'h0100, 14'h0100, 1'b0);
    check("R1 foreign strobes", status, 0);
    put(0, 14'h0100, 14'h0100, 1'b0);
    check("R1 own strobe", status, 16'h0100);
    clear();

    // filtered versus raw (R8)
    cfg_thr[15:0] = {2'b10, 14'd100};
    use_filt = 1'b0;
    put(0, 14'd50, 14'd200, 1'b0);
    check("R8 raw low", status[8], 0);
    use_filt = 1'b1;
    put(0, 14'd50, 14'd200, 1'b0);
    check("R8 filt high", status[8], 1);
    clear();
    put(0, 14'd200, 14'd50, 1'b0);
    check("R8 filt low", status[8], 0);
    use_filt = 1'b0;

    // sticky flag and read race (R6, R7)
    put(0, 14'd200, 14'd200, 1'b0);
    check("R6 set", status, 16'h0100);
    repeat (5) tick();
    check("R6 hold", status, 16'h0100);
    put(0, 14'd200, 14'd200, 1'b1);
    check("R7 read with event", status[8], 1);
    clear();
    check("R7 read clears", status[8], 0);
    cfg_src[2:0] = 3'b000;
    tick();

    // rate mode windows on channel 1 (R4, R5)
    for (int r = 0; r < 6; r++) begin
      int rs [6] = '{1, 1, 3, 0, 2, 1};
      int rn [6] = '{4, 0, 3, 5, 1, 2};
      int rdir [6] = '{1, 0, 1, 0, 1, 0};
      int rt [6] = '{3, -2, 0, 10, 5, 0};
      int s, n, prev, sum, cnt;
      bit ok;
      s = rs[r];
      n = (rn[r] == 0) ? 1 : rn[r];
      cfg_src[5:3] = 3'b000;
      tick();
      cfg_src[5:3] = codes[s][2:0];
      cfg_rate[1]  = 1'b1;
      cfg_win[15:8] = rn[r][7:0];
      cfg_thr[31:16] = {rdir[r][0], 1'b0, rt[r][13:0]};
      tick();
      ok = 0; sum = 0; cnt = 0; prev = 0;
      for (int k = 0; k < 40; k++) begin
        logic [13:0] v;
        int iv;
        bit e;
        if (s == 1 || s == 3) iv = ((k * 37 + r * 11) % 41) - 20;
        else iv = 1000 + ((k * k * 7 + r) % 60);
        v = iv[13:0];
        e = 0;
        if (!ok) begin
          ok = 1;
        end else begin
          sum += iv - prev;
          cnt++;
          if (cnt == n) begin
            e = rdir[r] ? (sum > rt[r] * n) : (sum < rt[r] * n);
            sum = 0;
            cnt = 0;
          end
        end
        prev = iv;
        put(s, v, v, 1'b0);
        check(rn[r] == 0 ? "R5 window of zero" : "R4 window mean", status[9], e);
        if (status[9]) clear();
      end
    end

    // reconfiguration discards the partial window (R11)
    cfg_src[5:3] = 3'b000;
    tick();
    cfg_src[5:3] = 3'b010;
    cfg_rate[1] = 1'b1;
    cfg_win[15:8] = 8'd2;
    cfg_thr[31:16] = {2'b10, 14'd0};
    tick();
    put(1, 14'd0, 14'd0, 1'b0);
    put(1, 14'd100, 14'd100, 1'b0);
    check("R11 partial window", status[9], 0);
    cfg_src[5:3] = 3'b110;
    tick();
    put(3, 14'd100, 14'd100, 1'b0);
    put(3, 14'd100, 14'd100, 1'b0);
    check("R11 no stale difference", status[9], 0);
    put(3, 14'd100, 14'd100, 1'b0);
    check("R11 zero mean", status[9], 0);
    put(3, 14'd150, 14'd150, 1'b0);
    put(3, 14'd200, 14'd200, 1'b0);
    check("R11 fresh window fires", status[9], 1);
    clear();
    cfg_src[5:3] = 3'b000;
    tick();

    // shared line priority (R9, R10)
    cfg_src[2:0] = 3'b001;
    cfg_rate[0] = 1'b0;
    cfg_thr[15:0] = {2'b10, 14'd100};
    gp_out = 2'b10;
    gp_oe  = 2'b01;
    for (int fl = 0; fl < 2; fl++) begin
      if (fl == 1) put(0, 14'd200, 14'd200, 1'b0);
      for (int m = 0; m < 32; m++) begin
        logic [1:0] eo, ee;
        {rdy_en, rdy_sel, pin_en, pin_sel, pin_pol} = m[4:0];
        rdy_lvl = ~m[0];
        #2;
        for (int l = 0; l < 2; l++) begin
          if (rdy_en && rdy_sel == l[0]) begin
            eo[l] = rdy_lvl; ee[l] = 1'b1;
          end else if (pin_en && pin_sel == l[0]) begin
            eo[l] = pin_pol ? fl[0] : ~fl[0]; ee[l] = 1'b1;
          end else begin
            eo[l] = gp_out[l]; ee[l] = gp_oe[l];
          end
        end
        check("R9 R10 line mux", {io_out, io_oe}, {eo, ee});
        tick();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule